// File: doc/BRIEF.md
# Flash Controller Command, Interrupt and Status Register Block

This block is the register front end of a NAND-style flash controller. Software reaches it through a single-cycle register port. It holds a command register, two system configuration registers, a controller status register and an interrupt status register, all 16 bits wide. A fixed write-protect status word can also be read. The block classifies each command word that is written. An array command goes out to the flash engine as a one-cycle start pulse. A reset command resets the block's own registers. A lock-type command raises the master interrupt at once. Any other code is flagged as a command error.

The flash engine reports each finished load, program or erase as a one-cycle event strobe with a kind code and an error flag. The block folds that event into the interrupt and status registers. While the master interrupt bit is set, new commands are refused, so software must acknowledge each completion before it issues the next command. Software acknowledges by writing a mask that is ANDed into the interrupt register. Once the master bit is clear, the latched error flags are dropped as well. A configuration bit sets the polarity of the interrupt pin, and another configuration bit drives the ready pin.

Top module: `fctl_regblk`

## Requirements
- R1: After a cold reset (`rst_n` low), the registers read as follows: command 0x0000, config-1 0x40C0, config-2 0x0000, status 0x0000, interrupt 0x8080, write-protect 0x0002. The `rdy` output is 1. Register indices on `reg_addr` are: 0 command, 1 config-1, 2 config-2, 3 status, 4 interrupt, 5 write-protect.
- R2: A warm reset loads the same values as a cold reset, except that interrupt status becomes 0x8010. A warm reset comes either from a `warm_rst` pulse or from an accepted command write of 0x00F0 or 0x00F3. A warm reset takes priority over any event or register write in the same cycle.
- R3: A write to the command register while interrupt bit 15 is set is ignored. The command register keeps its value and `cmd_go` stays low.
- R4: An accepted write of an array code (0x0000, 0x0013, 0x0080, 0x001A, 0x001B, 0x0094, 0x0095, 0x00B0, 0x0030) has these effects. The value is stored in the command register. `cmd_go` is high for exactly the one cycle after the write, and `cmd_code` shows the code.
- R5: An accepted write of a code that belongs to no class sets status bit 10 (command error) and interrupt bit 15. The value is stored in the command register, and `cmd_go` stays low.
- R6: An accepted write of a lock-type code (0x0023, 0x0027, 0x002A, 0x002C, 0x0071, 0x0065) sets interrupt bit 15. The status register is left unchanged, and `cmd_go` stays low.
- R7: A write to the interrupt register replaces its contents with the bitwise AND of the old value and the written value.
- R8: If interrupt bit 15 is clear after an interrupt-register write, status bits 10 to 13 are cleared. If bit 15 is still set, those status bits are kept.
- R9: An event strobe sets interrupt bit 15 plus a done bit. Kind 0 (load) sets bit 7, kind 1 (program) sets bit 6 and kind 2 (erase) sets bit 5. With the error flag set, the strobe also sets status bit 10 together with bit 13 (load), bit 12 (program) or bit 11 (erase). Kind 3 has no effect.
- R10: When an event and an interrupt-register write fall in the same cycle, the AND and the error clearing are applied first, and the event's bits are added afterwards.
- R11: The `irq` output equals interrupt bit 15 XOR the inverse of config-1 bit 6. It reflects a config-1 or interrupt write from the cycle after that write.
- R12: On each config-1 write, `rdy` takes the value of written bit 7. Between config-1 writes, `rdy` holds that value.
- R13: Config-1 reads back with bits 4..0 forced to zero. Config-2 reads back the full written value.
- R14: Writes to the status and write-protect registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold reset, asynchronous assert, active low |
| warm_rst | input | 1 | Synchronous warm reset request, one cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register index |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| evt_vld | input | 1 | Completion event strobe from the flash engine |
| evt_kind | input | 2 | Event kind: 0 load, 1 program, 2 erase, 3 none |
| evt_err | input | 1 | The completed operation failed |
| cmd_go | output | 1 | One-cycle start pulse for an array command |
| cmd_code | output | 16 | Current command register value |
| irq | output | 1 | Interrupt pin, polarity set by config-1 bit 6 |
| rdy | output | 1 | Ready pin, set from config-1 bit 7 when config-1 is written |

## Verification
The assertions assume that the register port and the event strobe are driven synchronously to `clk`. They also assume that `evt_kind` only matters while `evt_vld` is high and that `warm_rst` is a clean one-cycle pulse. The checks on `cmd_go` and on the event path also rely on a command write and a warm reset never landing in the same cycle as the effect being checked. The bench drives every input on the falling edge and holds each write or event for exactly one cycle. It keeps warm resets apart from the other stimulus, and it clears the master interrupt before each command it expects to be accepted.

// File: rtl/fctl_pkg.sv
package fctl_pkg;

  localparam int unsigned REG_W = 16;

  // register indices on the register port
  localparam int unsigned RA_CMD  = 0;
  localparam int unsigned RA_CFG1 = 1;
  localparam int unsigned RA_CFG2 = 2;
  localparam int unsigned RA_STAT = 3;
  localparam int unsigned RA_INT  = 4;
  localparam int unsigned RA_WP   = 5;

  // interrupt status bit positions
  localparam int unsigned IB_RST    = 4;
  localparam int unsigned IB_ERASE  = 5;
  localparam int unsigned IB_PROG   = 6;
  localparam int unsigned IB_LOAD   = 7;
  localparam int unsigned IB_MASTER = 15;

  // controller status bit positions
  localparam int unsigned SB_CMD   = 10;
  localparam int unsigned SB_ERASE = 11;
  localparam int unsigned SB_PROG  = 12;
  localparam int unsigned SB_LOAD  = 13;

  // configuration-1 bit positions
  localparam int unsigned CB_POL = 6;
  localparam int unsigned CB_RDY = 7;

  localparam logic [REG_W-1:0] ERR_MASK =
    REG_W'((1 << SB_CMD) | (1 << SB_ERASE) | (1 << SB_PROG) | (1 << SB_LOAD));
  localparam logic [REG_W-1:0] CFG1_RD_MASK = 16'hFFE0;

  localparam logic [REG_W-1:0] CFG1_RST    = 16'h40C0;
  localparam logic [REG_W-1:0] WP_VALUE    = 16'h0002;
  localparam logic [REG_W-1:0] INT_COLD    = REG_W'((1 << IB_MASTER) | (1 << IB_LOAD));
  localparam logic [REG_W-1:0] INT_WARM    = REG_W'((1 << IB_MASTER) | (1 << IB_RST));

  typedef enum logic [1:0] {
    CLS_ARRAY = 2'd0,
    CLS_IMM   = 2'd1,
    CLS_RESET = 2'd2,
    CLS_BAD   = 2'd3
  } cmd_cls_e;

  typedef enum logic [1:0] {
    EK_LOAD  = 2'd0,
    EK_PROG  = 2'd1,
    EK_ERASE = 2'd2,
    EK_NONE  = 2'd3
  } evt_kind_e;

endpackage

// File: rtl/fctl_cmd_class.sv
module fctl_cmd_class
  import fctl_pkg::*;
(
  input  logic [REG_W-1:0] code,
  output cmd_cls_e         cls
);

  always_comb begin
    unique case (code)
      16'h0000, 16'h0013, 16'h0080, 16'h001A, 16'h001B,
      16'h0094, 16'h0095, 16'h00B0, 16'h0030:
        cls = CLS_ARRAY;
      16'h0023, 16'h0027, 16'h002A, 16'h002C, 16'h0071, 16'h0065:
        cls = CLS_IMM;
      16'h00F0, 16'h00F3:
        cls = CLS_RESET;
      default:
        cls = CLS_BAD;
    endcase
  end

endmodule

// File: rtl/fctl_evt_map.sv
module fctl_evt_map
  import fctl_pkg::*;
(
  input  logic             evt_vld,
  input  logic [1:0]       evt_kind,
  input  logic             evt_err,
  output logic [REG_W-1:0] int_set,
  output logic [REG_W-1:0] st_set
);

  logic [REG_W-1:0] done_bit;
  logic [REG_W-1:0] err_bit;
  logic             kind_ok;

  always_comb begin
    done_bit = '0;
    err_bit  = '0;
    kind_ok  = 1'b1;
    unique case (evt_kind_e'(evt_kind))
      EK_LOAD:  begin done_bit[IB_LOAD]  = 1'b1; err_bit[SB_LOAD]  = 1'b1; end
      EK_PROG:  begin done_bit[IB_PROG]  = 1'b1; err_bit[SB_PROG]  = 1'b1; end
      EK_ERASE: begin done_bit[IB_ERASE] = 1'b1; err_bit[SB_ERASE] = 1'b1; end
      default:  kind_ok = 1'b0;
    endcase
  end

  always_comb begin
    int_set = '0;
    st_set  = '0;
    if (evt_vld && kind_ok) begin
      int_set            = done_bit;
      int_set[IB_MASTER] = 1'b1;
      if (evt_err) begin
        st_set         = err_bit;
        st_set[SB_CMD] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/fctl_irq_next.sv
module fctl_irq_next
  import fctl_pkg::*;
(
  input  logic [REG_W-1:0] int_q,
  input  logic [REG_W-1:0] st_q,
  input  logic             int_wr,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] int_set,
  input  logic [REG_W-1:0] st_set,
  input  logic             cmd_bad,
  input  logic             cmd_imm,
  output logic [REG_W-1:0] int_nxt,
  output logic [REG_W-1:0] st_nxt
);

  logic [REG_W-1:0] int_acked;
  logic [REG_W-1:0] st_base;
  logic [REG_W-1:0] cmd_int;
  logic [REG_W-1:0] cmd_st;

  // acknowledge first, then merge new events
  assign int_acked = int_wr ? (int_q & wdata) : int_q;
  assign st_base   = (int_wr && !int_acked[IB_MASTER]) ? (st_q & ~ERR_MASK) : st_q;

  always_comb begin
    cmd_int = '0;
    cmd_st  = '0;
    if (cmd_bad || cmd_imm) cmd_int[IB_MASTER] = 1'b1;
    if (cmd_bad)            cmd_st[SB_CMD]     = 1'b1;
  end

  assign int_nxt = int_acked | int_set | cmd_int;
  assign st_nxt  = st_base | st_set | cmd_st;

endmodule

// File: rtl/fctl_regblk.sv
module fctl_regblk
  import fctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic              evt_vld,
  input  logic [1:0]        evt_kind,
  input  logic              evt_err,
  output logic              cmd_go,
  output logic [15:0]       cmd_code,
  output logic              irq,
  output logic              rdy
);

  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(RA_CMD);
  localparam logic [ADDR_W-1:0] A_CFG1 = ADDR_W'(RA_CFG1);
  localparam logic [ADDR_W-1:0] A_CFG2 = ADDR_W'(RA_CFG2);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(RA_STAT);
  localparam logic [ADDR_W-1:0] A_INT  = ADDR_W'(RA_INT);
  localparam logic [ADDR_W-1:0] A_WP   = ADDR_W'(RA_WP);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  // state
  logic [REG_W-1:0] cmd_q,  cmd_d;
  logic [REG_W-1:0] cfg1_q, cfg1_d;
  logic [REG_W-1:0] cfg2_q, cfg2_d;
  logic [REG_W-1:0] st_q,   st_d;
  logic [REG_W-1:0] int_q,  int_d;
  logic             rdy_q,  rdy_d;
  logic             go_q,   go_d;

  // decode
  logic     wr_cmd, wr_cfg1, wr_cfg2, wr_int;
  logic     cmd_accept;
  logic     soft_rst, any_warm;
  cmd_cls_e cls;

  assign wr_cmd  = reg_wr && (reg_addr == A_CMD);
  assign wr_cfg1 = reg_wr && (reg_addr == A_CFG1);
  assign wr_cfg2 = reg_wr && (reg_addr == A_CFG2);
  assign wr_int  = reg_wr && (reg_addr == A_INT);

  assign cmd_accept = wr_cmd && !int_q[IB_MASTER];

  fctl_cmd_class u_cls (
    .code (reg_wdata),
    .cls  (cls)
  );

  assign soft_rst = cmd_accept && (cls == CLS_RESET);
  assign any_warm = warm_rst || soft_rst;

  logic [REG_W-1:0] evt_int_set, evt_st_set;

  fctl_evt_map u_evt (
    .evt_vld  (evt_vld),
    .evt_kind (evt_kind),
    .evt_err  (evt_err),
    .int_set  (evt_int_set),
    .st_set   (evt_st_set)
  );

  logic [REG_W-1:0] int_upd, st_upd;

  fctl_irq_next u_nxt (
    .int_q   (int_q),
    .st_q    (st_q),
    .int_wr  (wr_int),
    .wdata   (reg_wdata),
    .int_set (evt_int_set),
    .st_set  (evt_st_set),
    .cmd_bad (cmd_accept && (cls == CLS_BAD)),
    .cmd_imm (cmd_accept && (cls == CLS_IMM)),
    .int_nxt (int_upd),
    .st_nxt  (st_upd)
  );

  // next state
  always_comb begin
    cmd_d  = cmd_q;
    cfg1_d = cfg1_q;
    cfg2_d = cfg2_q;
    st_d   = st_q;
    int_d  = int_q;
    rdy_d  = rdy_q;
    go_d   = 1'b0;
    if (any_warm) begin
      cmd_d  = '0;
      cfg1_d = CFG1_RST;
      cfg2_d = '0;
      st_d   = '0;
      int_d  = INT_WARM;
      rdy_d  = 1'b1;
    end else begin
      if (cmd_accept) cmd_d = reg_wdata;
      if (wr_cfg1) begin
        cfg1_d = reg_wdata;
        rdy_d  = reg_wdata[CB_RDY];
      end
      if (wr_cfg2) cfg2_d = reg_wdata;
      st_d  = st_upd;
      int_d = int_upd;
      go_d  = cmd_accept && (cls == CLS_ARRAY);
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      cmd_q  <= '0;
      cfg1_q <= CFG1_RST;
      cfg2_q <= '0;
      st_q   <= '0;
      int_q  <= INT_COLD;
      rdy_q  <= 1'b1;
      go_q   <= 1'b0;
    end else begin
      cmd_q  <= cmd_d;
      cfg1_q <= cfg1_d;
      cfg2_q <= cfg2_d;
      st_q   <= st_d;
      int_q  <= int_d;
      rdy_q  <= rdy_d;
      go_q   <= go_d;
    end
  end

  // read mux
  always_comb begin
    unique case (reg_addr)
      A_CMD:   reg_rdata = cmd_q;
      A_CFG1:  reg_rdata = cfg1_q & CFG1_RD_MASK;
      A_CFG2:  reg_rdata = cfg2_q;
      A_STAT:  reg_rdata = st_q;
      A_INT:   reg_rdata = int_q;
      A_WP:    reg_rdata = WP_VALUE;
      default: reg_rdata = '0;
    endcase
  end

  assign cmd_go   = go_q;
  assign cmd_code = cmd_q;
  assign irq      = int_q[IB_MASTER] ^ ~cfg1_q[CB_POL];
  assign rdy      = rdy_q;

endmodule

// File: rtl/fctl_regblk_chk.sv
module fctl_regblk_chk
  import fctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_s,
  input logic              warm_rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [15:0]       reg_wdata,
  input logic              evt_vld,
  input logic [1:0]        evt_kind,
  input logic              cmd_go,
  input logic              irq,
  input logic              rdy,
  input logic [15:0]       int_q,
  input logic [15:0]       st_q
);

  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(RA_CMD);
  localparam logic [ADDR_W-1:0] A_CFG1 = ADDR_W'(RA_CFG1);

  // R3
  gated_cmd_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (reg_wr && reg_addr == A_CMD && int_q[IB_MASTER]) |=> !cmd_go);

  // R4
  go_origin_chk: assert property (@(posedge clk) disable iff (!rst_s)
    cmd_go |-> $past(reg_wr && reg_addr == A_CMD && !int_q[IB_MASTER]));

  // R8
  err_needs_master_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !int_q[IB_MASTER] |-> ((st_q & ERR_MASK) == '0));

  // R9
  evt_raises_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (evt_vld && evt_kind != 2'd3 && !warm_rst && !(reg_wr && reg_addr == A_CMD))
      |=> int_q[IB_MASTER]);

  // R11
  irq_polarity_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (reg_wr && reg_addr == A_CFG1 && !warm_rst)
      |=> (irq == (int_q[IB_MASTER] ^ ~$past(reg_wdata[CB_POL]))));

  // R12
  rdy_fall_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $fell(rdy) |-> $past(reg_wr && reg_addr == A_CFG1 && !reg_wdata[CB_RDY]));

endmodule

bind fctl_regblk fctl_regblk_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_s     (rst_s),
  .warm_rst  (warm_rst),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .evt_vld   (evt_vld),
  .evt_kind  (evt_kind),
  .cmd_go    (cmd_go),
  .irq       (irq),
  .rdy       (rdy),
  .int_q     (int_q),
  .st_q      (st_q)
);

// File: tb/sim_fctl_regblk.sv
`timescale 1ns/1ps
module sim_fctl_regblk;

  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          warm_rst;
  logic          reg_wr;
  logic [AW-1:0] reg_addr;
  logic [15:0]   reg_wdata;
  logic [15:0]   reg_rdata;
  logic          evt_vld;
  logic [1:0]    evt_kind;
  logic          evt_err;
  logic          cmd_go;
  logic [15:0]   cmd_code;
  logic          irq;
  logic          rdy;

  int n_chk  = 0;
  int n_fail = 0;
  bit over   = 0;

  always #2.5 clk = ~clk;

  fctl_regblk #(.ADDR_W(AW)) u0 (
    .clk, .rst_n, .warm_rst, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .evt_vld, .evt_kind, .evt_err, .cmd_go, .cmd_code, .irq, .rdy
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = AW'(a);
    #1 d = reg_rdata;
  endtask

  task automatic rd_chk(input string req, input int a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic evt(input logic [1:0] k, input logic e);
    @(negedge clk);
    evt_vld = 1'b1; evt_kind = k; evt_err = e;
    @(negedge clk);
    evt_vld = 1'b0;
  endtask

  task automatic t_cold;
    rd_chk("R1 cmd", 0, 16'h0000);
    rd_chk("R1 cfg1", 1, 16'h40C0);
    rd_chk("R1 cfg2", 2, 16'h0000);
    rd_chk("R1 status", 3, 16'h0000);
    rd_chk("R1 int", 4, 16'h8080);
    rd_chk("R1 wp", 5, 16'h0002);
    chk("R1 rdy", {15'd0, rdy}, 16'd1);
    chk("R11 irq after reset", {15'd0, irq}, 16'd1);
  endtask

  task automatic t_gate;
    wr(0, 16'h0080);
    chk("R3 no go", {15'd0, cmd_go}, 16'd0);
    rd_chk("R3 cmd kept", 0, 16'h0000);
  endtask

  task automatic t_ack;
    wr(4, 16'h7FFF);
    rd_chk("R7 and 7FFF", 4, 16'h0080);
    chk("R11 irq low", {15'd0, irq}, 16'd0);
    wr(4, 16'hFFFF);
    rd_chk("R7 and FFFF", 4, 16'h0080);
    wr(4, 16'h0000);
    rd_chk("R7 and 0", 4, 16'h0000);
  endtask

  task automatic t_array;
    wr(0, 16'h0080);
    chk("R4 go high", {15'd0, cmd_go}, 16'd1);
    chk("R4 code", cmd_code, 16'h0080);
    @(negedge clk);
    chk("R4 go one cycle", {15'd0, cmd_go}, 16'd0);
    rd_chk("R4 cmd reg", 0, 16'h0080);
  endtask

  task automatic t_evt_err;
    evt(2'd1, 1'b1);
    rd_chk("R9 prog int", 4, 16'h8040);
    rd_chk("R9 prog err", 3, 16'h1400);
    chk("R11 irq high", {15'd0, irq}, 16'd1);
    wr(0, 16'h0000);
    chk("R3 gated go", {15'd0, cmd_go}, 16'd0);
    rd_chk("R3 gated cmd", 0, 16'h0080);
    wr(4, 16'hFFBF);
    rd_chk("R7 partial", 4, 16'h8000);
    rd_chk("R8 err kept", 3, 16'h1400);
    wr(4, 16'h7FFF);
    rd_chk("R8 int cleared", 4, 16'h0000);
    rd_chk("R8 err cleared", 3, 16'h0000);
  endtask

  task automatic t_bad_imm;
    wr(0, 16'h0055);
    chk("R5 no go", {15'd0, cmd_go}, 16'd0);
    rd_chk("R5 status", 3, 16'h0400);
    rd_chk("R5 int", 4, 16'h8000);
    rd_chk("R5 cmd stored", 0, 16'h0055);
    wr(4, 16'h0000);
    wr(0, 16'h0023);
    chk("R6 no go", {15'd0, cmd_go}, 16'd0);
    rd_chk("R6 int", 4, 16'h8000);
    rd_chk("R6 status", 3, 16'h0000);
    wr(4, 16'h0000);
  endtask

  task automatic t_kinds;
    evt(2'd0, 1'b0);
    rd_chk("R9 load int", 4, 16'h8080);
    rd_chk("R9 load no err", 3, 16'h0000);
    evt(2'd2, 1'b1);
    rd_chk("R9 erase int", 4, 16'h80A0);
    rd_chk("R9 erase err", 3, 16'h0C00);
    wr(4, 16'h0000);
    evt(2'd3, 1'b1);
    rd_chk("R9 kind3 int", 4, 16'h0000);
    rd_chk("R9 kind3 status", 3, 16'h0000);
  endtask

  task automatic t_same_cycle;
    evt(2'd1, 1'b1);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(4); reg_wdata = 16'h0000;
    evt_vld = 1'b1; evt_kind = 2'd2; evt_err = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; evt_vld = 1'b0;
    rd_chk("R10 int", 4, 16'h8020);
    rd_chk("R10 status", 3, 16'h0C00);
    wr(4, 16'h0000);
  endtask

  task automatic t_cfg;
    wr(1, 16'h0055);
    rd_chk("R13 cfg1 mask", 1, 16'h0040);
    chk("R12 rdy low", {15'd0, rdy}, 16'd0);
    chk("R11 irq pol high-active idle", {15'd0, irq}, 16'd0);
    wr(1, 16'h0000);
    chk("R11 irq pol low-active idle", {15'd0, irq}, 16'd1);
    chk("R12 rdy stays low", {15'd0, rdy}, 16'd0);
    wr(1, 16'h0080);
    chk("R12 rdy high", {15'd0, rdy}, 16'd1);
    wr(2, 16'hABCD);
    rd_chk("R13 cfg2", 2, 16'hABCD);
    wr(3, 16'hFFFF);
    rd_chk("R14 status ro", 3, 16'h0000);
    wr(5, 16'hFFFF);
    rd_chk("R14 wp ro", 5, 16'h0002);
  endtask

  task automatic t_warm_cmd(input logic [15:0] code);
    wr(1, 16'h0000);
    wr(2, 16'h1234);
    wr(0, code);
    chk("R2 no go", {15'd0, cmd_go}, 16'd0);
    rd_chk("R2 int", 4, 16'h8010);
    rd_chk("R2 cfg1", 1, 16'h40C0);
    rd_chk("R2 cfg2", 2, 16'h0000);
    rd_chk("R2 cmd", 0, 16'h0000);
    chk("R2 rdy", {15'd0, rdy}, 16'd1);
    wr(4, 16'h0000);
  endtask

  task automatic t_warm_pin;
    wr(2, 16'h00FF);
    evt(2'd0, 1'b1);
    @(negedge clk);
    warm_rst = 1'b1;
    @(negedge clk);
    warm_rst = 1'b0;
    rd_chk("R2 pin int", 4, 16'h8010);
    rd_chk("R2 pin status", 3, 16'h0000);
    rd_chk("R2 pin cfg2", 2, 16'h0000);
  endtask

  initial begin
    rst_n = 1'b0; warm_rst = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    evt_vld = 1'b0; evt_kind = '0; evt_err = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_cold();
    t_gate();
    t_ack();
    t_array();
    t_evt_err();
    t_bad_imm();
    t_kinds();
    t_same_cycle();
    t_cfg();
    t_warm_cmd(16'h00F0);
    t_warm_cmd(16'h00F3);
    t_warm_pin();
    if (!over) begin
      over = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!over) begin
      over = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule